// File: doc/BRIEF.md
# Four-Phase Handshake Pipeline FIFO

This block buffers words between a producer and a consumer that both speak a four-phase request/acknowledge protocol with bundled data. The producer can hand a word over and receive its acknowledge before the consumer is ready, so the producer need not wait for the consumer to finish its own work. The buffer is a chain of identical stages. Each stage has one C-element control cell that joins the request from the stage before it with the inverted acknowledge from the stage after it, and one data register that loads from the stage before it when its control cell rises.

The control cells are evaluated once per clock edge. Each cell therefore acts as a unit-delay C-element, and a token moves one stage per clock. A token and a bubble must alternate along the chain. A stalled chain of STAGES cells thus holds STAGES/2 words, and the stage count must be even. The acknowledge to the producer is the first cell's output. The request to the consumer is the last cell's output. The consumer reads its data from the last stage's register.

Top module: `muller_fifo`

## Requirements
- R1: After reset all control cells are 0, so `inAck` and `outReq` read 0 and stay 0 until a request arrives.
- R2: A control cell changes only when its two inputs agree: the request from upstream and the inverted acknowledge from downstream. When they differ it holds its value, so a producer request that meets a full chain gets no acknowledge.
- R3: `inAck` rises only after an edge at which `inReq` was high, and it falls only after an edge at which `inReq` was low.
- R4: `outReq` rises only after an edge at which `outAck` was low, and it falls only after an edge at which `outAck` was high. Once the chain has drained, `inAck` and `outReq` both return to 0.
- R5: Words reach `outData` in the order they entered, with no loss and no duplication, whatever the relative speeds of producer and consumer. A stage register changes only when that stage loads.
- R6: While the consumer does not acknowledge, the chain accepts exactly STAGES/2 words. Further requests stay unacknowledged.
- R7: While `outReq` stays high, `outData` does not change.
- R8: In an empty chain, `outReq` reads 1 after the STAGES-th rising edge that follows the raising of `inReq`. `inAck` reads 1 after the first of those edges.
- R9: A word is captured on the edge at which the first control cell rises. If `inData` changes after `inAck` is seen high, the delivered word is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Evaluation clock for the control cells and stage registers |
| rstN | input | 1 | Active-low reset; clears every control cell and stage register |
| inReq | input | 1 | Producer request, four-phase |
| inData | input | WIDTH | Producer word, stable while inReq is high until inAck is seen |
| inAck | output | 1 | Acknowledge to the producer (first control cell) |
| outReq | output | 1 | Request to the consumer (last control cell) |
| outData | output | WIDTH | Word offered to the consumer (last stage register) |
| outAck | input | 1 | Consumer acknowledge, four-phase |

## Verification
A word can enter the first stage on the same edge that the consumer's acknowledge drains the last stage. When the chain is full, a bubble freed at the output travels back toward the input while new tokens move forward. Both overlaps are provoked by running producer and consumer at the same time with independent random waits of zero to three cycles over a long stream. Every delivered word is compared with a queue of sent words held in the bench. A directed phase first fills the chain against a stalled consumer and then drains it, so that acceptance at the input and release at the output meet at the capacity limit.

// File: rtl/muller_pkg.sv
package muller_pkg;

  // Muller C-element: follows the inputs when they agree, otherwise holds.
  function automatic logic cElem(input logic a, input logic b, input logic hold);
    return (a & b) | (hold & (a | b));
  endfunction

endpackage

// File: rtl/muller_ctrl.sv
module muller_ctrl
  import muller_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inReq,
  input  logic              outAck,
  output logic [STAGES-1:0] stageState,
  output logic [STAGES-1:0] loadEn
);

  logic [STAGES-1:0] reqVec;
  logic [STAGES-1:0] ackVec;
  logic [STAGES-1:0] nextState;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign reqVec[i] = inReq;
    end else begin : g_mid_req
      assign reqVec[i] = stageState[i-1];
    end
    if (i == STAGES - 1) begin : g_last
      assign ackVec[i] = outAck;
    end else begin : g_mid_ack
      assign ackVec[i] = stageState[i+1];
    end

    assign nextState[i] = cElem(reqVec[i], ~ackVec[i], stageState[i]);
    assign loadEn[i]    = nextState[i] & ~stageState[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageState[i] <= 1'b0;
      else       stageState[i] <= nextState[i];
    end

    // R2
    c_element_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(stageState[i]) |-> ($past(reqVec[i]) == !$past(ackVec[i])));
  end

endmodule

// File: rtl/muller_data.sv
module muller_data #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WIDTH-1:0]  inData,
  input  logic [STAGES-1:0] loadEn,
  output logic [WIDTH-1:0]  outData
);

  logic [WIDTH-1:0] slot [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_slot
    logic [WIDTH-1:0] src;
    if (i == 0) begin : g_src_in
      assign src = inData;
    end else begin : g_src_prev
      assign src = slot[i-1];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          slot[i] <= '0;
      else if (loadEn[i]) slot[i] <= src;
    end

    // R5
    slot_load_only_chk: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(slot[i]) |-> $past(loadEn[i]));
  end

  assign outData = slot[STAGES-1];

endmodule

// File: rtl/muller_fifo.sv
module muller_fifo #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inReq,
  input  logic [WIDTH-1:0] inData,
  output logic             inAck,
  output logic             outReq,
  output logic [WIDTH-1:0] outData,
  input  logic             outAck
);

  localparam int HELD = STAGES / 2;

  if (STAGES < 2 || (STAGES % 2) != 0) begin : g_bad_cfg
    $error("muller_fifo: STAGES must be even and at least 2");
  end

  logic [STAGES-1:0] stageState;
  logic [STAGES-1:0] loadEn;

  muller_ctrl #(.STAGES(STAGES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inReq     (inReq),
    .outAck    (outAck),
    .stageState(stageState),
    .loadEn    (loadEn)
  );

  muller_data #(.WIDTH(WIDTH), .STAGES(STAGES)) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .inData (inData),
    .loadEn (loadEn),
    .outData(outData)
  );

  assign inAck  = stageState[0];
  assign outReq = stageState[STAGES-1];

  // R3
  in_ack_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inAck) |-> $past(inReq));
  // R3
  in_ack_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inAck) |-> !$past(inReq));
  // R4
  out_req_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outReq) |-> !$past(outAck));
  // R4
  out_req_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outReq) |-> $past(outAck));
  // R7
  out_data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outReq && $past(outReq)) |-> $stable(outData));
  // R6
  occupancy_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(loadEn) <= HELD);

endmodule

// File: tb/test_muller_fifo.sv
module test_muller_fifo;
  localparam int WIDTH  = 8;
  localparam int STAGES = 4;
  localparam int NRAND  = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inReq = 1'b0;
  logic outAck = 1'b0;
  logic [WIDTH-1:0] inData = '0;
  logic inAck, outReq;
  logic [WIDTH-1:0] outData;

  int checks = 0;
  int errors = 0;
  logic [WIDTH-1:0] expQ[$];

  always #5 clk = ~clk;

  muller_fifo #(.WIDTH(WIDTH), .STAGES(STAGES)) i_muller_fifo (
    .clk(clk), .rstN(rstN), .inReq(inReq), .inData(inData), .inAck(inAck),
    .outReq(outReq), .outData(outData), .outAck(outAck)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pushOne(input logic [WIDTH-1:0] d, input int limit, output bit took);
    @(negedge clk);
    inData = d;
    inReq  = 1'b1;
    took   = 1'b0;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      if (inAck) begin
        took = 1'b1;
        break;
      end
    end
    if (took) inData = ~d;   // R9: scramble after capture
    inReq = 1'b0;
    while (inAck) @(negedge clk);
  endtask

  task automatic popOne(input string req);
    while (!outReq) @(negedge clk);
    if (expQ.size() == 0) begin
      check(1'b0, req, outData, -1);
    end else begin
      check(outData == expQ[0], req, outData, expQ[0]);
      void'(expQ.pop_front());
    end
    outAck = 1'b1;
    do @(negedge clk); while (outReq);
    outAck = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit took;
    int cnt;
    int accepted;
    logic [WIDTH-1:0] held;
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    check(inAck == 1'b0, "R1", inAck, 0);
    check(outReq == 1'b0, "R1", outReq, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(inAck == 1'b0 && outReq == 1'b0, "R1", {inAck, outReq}, 0);

    // R8 latency through an empty chain
    inData = 8'hA5;
    inReq  = 1'b1;
    expQ.push_back(8'hA5);
    cnt = 0;
    @(negedge clk);
    cnt++;
    check(inAck == 1'b1, "R8", inAck, 1);
    while (!outReq && cnt < 50) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == STAGES, "R8", cnt, STAGES);
    inReq = 1'b0;
    while (inAck) @(negedge clk);
    popOne("R5");

    // R6 capacity with a stalled consumer, R9 scrambled input
    accepted = 0;
    for (int n = 0; n < STAGES; n++) begin
      logic [WIDTH-1:0] d;
      d = 8'h10 + 8'(n);
      expQ.push_back(d);
      pushOne(d, 20, took);
      if (took) accepted++;
      else begin
        void'(expQ.pop_back());
        check(inAck == 1'b0, "R2", inAck, 0);
        break;
      end
    end
    check(accepted == STAGES / 2, "R6", accepted, STAGES / 2);
    held = outData;
    repeat (10) @(negedge clk);
    check(outReq == 1'b1 && outData == held, "R7", outData, held);
    for (int n = 0; n < accepted; n++) popOne("R9");

    // R5 random concurrent stream
    fork
      begin
        for (int n = 0; n < NRAND; n++) begin
          logic [WIDTH-1:0] d;
          d = WIDTH'($urandom);
          repeat ($urandom % 4) @(negedge clk);
          expQ.push_back(d);
          pushOne(d, 1000, took);
          if (!took) check(1'b0, "R5", 0, 1);
        end
      end
      begin
        for (int n = 0; n < NRAND; n++) begin
          repeat ($urandom % 4) @(negedge clk);
          popOne("R5");
        end
      end
    join

    repeat (10) @(negedge clk);
    check(inAck == 1'b0 && outReq == 1'b0, "R4", {inAck, outReq}, 0);
    check(expQ.size() == 0, "R5", expQ.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule